// File: doc/BRIEF.md
# Selectable Word Alignment Marker Detector

This block watches the decoded code-group stream of one receive lane and raises a one-clock pulse when it sees the alignment marker chosen by a two-bit mode select. A deskew stage that spans several lanes uses the pulse to find the code group it must line up across all lanes. The 8b/10b decoder ahead of this block reports three flags with each code group: the group is an IDLE, the group is the K28.3 control character, and the group arrived with a running-disparity error.

Each code group is offered with `grp_valid`. The block has no `ready` output: it accepts every valid group in the cycle it is offered and never applies back-pressure. A cycle with `grp_valid` low is a gap in the stream. Gaps leave the pattern state untouched, so a run may continue across them. The marker choice is static in normal use. When the select does change, the block restarts cleanly.

Top module: `wordsync_event_det`

## Requirements
- R1: With mode 2'b00, no code group ever raises `sync_event`.
- R2: With mode 2'b01, a non-IDLE group that directly follows at least four consecutive IDLE groups raises `sync_event` for exactly the cycle after that non-IDLE group is accepted.
- R3: With mode 2'b01, a run of fewer than four IDLEs before the non-IDLE group raises no event. A run longer than four IDLEs raises exactly one event, at the non-IDLE group that ends the run.
- R4: With mode 2'b10, sixteen consecutive IDLE groups raise `sync_event` in the cycle after the sixteenth is accepted, provided the disparity error flag is set on the 2nd and 3rd IDLE of the run and clear on all the others.
- R5: With mode 2'b10, the run restarts on any of these: a non-IDLE group, an IDLE at a position other than 2 or 3 that has a disparity error, or an IDLE at position 2 or 3 that has no disparity error. A restarting IDLE that has no disparity error counts as position 1 of the new run.
- R6: With mode 2'b10, IDLEs received after the sixteenth raise no further event until a non-IDLE group ends the run.
- R7: With mode 2'b11, every accepted K28.3 group raises `sync_event` in the following cycle. Back-to-back K28.3 groups give back-to-back pulses.
- R8: A cycle with `grp_valid` low raises no event and does not alter any run in progress.
- R9: In a cycle whose `mode` differs from the value it had in the previous cycle, the offered group is discarded and every pattern counter is cleared. After reset, the previous mode is taken to be 2'b00.
- R10: `sync_event` is a registered output and is low during reset and in the first cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Marker select: 00 off, 01 four-IDLE/non-IDLE, 10 disparity-marked IDLE run, 11 K28.3 |
| grp_valid | input | 1 | A decoded code group is offered this cycle |
| grp_idle | input | 1 | The offered group is an IDLE |
| grp_k28_3 | input | 1 | The offered group is the K28.3 control character |
| grp_disp_err | input | 1 | The offered group has a running-disparity error |
| sync_event | output | 1 | One-clock marker pulse, registered |

## Verification
Every result of this block is due one clock after the group that causes it: the group captured at a rising edge sets or clears `sync_event` at that same edge. So the pulse belonging to a group is visible throughout the following cycle. The bench changes inputs on the falling edge and reads `sync_event` a quarter period after the next rising edge. Each check therefore pairs exactly one offered group with the event value that group must produce, including the discarded group in a mode-change cycle and gap cycles with `grp_valid` low.

// File: rtl/wsd_pkg.sv
package wsd_pkg;
  typedef enum logic [1:0] {
    WS_OFF      = 2'b00,
    WS_FOUR_ONE = 2'b01,
    WS_DISP_RUN = 2'b10,
    WS_ACHAR    = 2'b11
  } ws_mode_e;

  localparam int unsigned GAP_RUN_LEN  = 4;
  localparam int unsigned DISP_RUN_LEN = 16;
  localparam int unsigned DISP_ERR_LO  = 2;
  localparam int unsigned DISP_ERR_HI  = 3;
endpackage

// File: rtl/wsd_mode_ctrl.sv
module wsd_mode_ctrl
  import wsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       grp_valid,
  output logic       clr,
  output logic       en_gap,
  output logic       en_disp,
  output logic       en_achar
);
  ws_mode_e mode_q;
  ws_mode_e mode_c;
  logic     take;

  assign mode_c = ws_mode_e'(mode);

  // Mode register: a change of select discards the group offered in that cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= WS_OFF;
    else        mode_q <= mode_c;
  end

  assign clr      = (mode_c != mode_q);
  assign take     = grp_valid && !clr;
  assign en_gap   = take && (mode_c == WS_FOUR_ONE);
  assign en_disp  = take && (mode_c == WS_DISP_RUN);
  assign en_achar = take && (mode_c == WS_ACHAR);
endmodule

// File: rtl/wsd_gap_det.sv
module wsd_gap_det #(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic idle,
  output logic hit
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q;

  // Saturating count of the IDLE run; a non-IDLE ends it.
  assign hit = en && !idle && (cnt_q == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      if (!idle)              cnt_q <= '0;
      else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wsd_disp_run_det.sv
module wsd_disp_run_det #(
  parameter int unsigned RUN_LEN = 16,
  parameter int unsigned ERR_LO  = 2,
  parameter int unsigned ERR_HI  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic idle,
  input  logic derr,
  output logic hit
);
  localparam int unsigned CW = $clog2(RUN_LEN + 2);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);
  localparam logic [CW-1:0] LO   = CW'(ERR_LO);
  localparam logic [CW-1:0] HI   = CW'(ERR_HI);

  logic [CW-1:0] pos_q;
  logic [CW-1:0] nxt;
  logic          want_err;
  logic          sat;
  logic          fits;

  // Position the offered IDLE would take, and the disparity it must show there.
  assign nxt      = pos_q + 1'b1;
  assign want_err = (nxt >= LO) && (nxt <= HI);
  assign sat      = (pos_q == FULL);
  assign fits     = idle && (derr == want_err);
  assign hit      = en && !sat && fits && (nxt == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pos_q <= '0;
    end else if (en) begin
      if (!idle)      pos_q <= '0;
      else if (sat)   pos_q <= pos_q;
      else if (fits)  pos_q <= nxt;
      else if (!derr) pos_q <= CW'(1);
      else            pos_q <= '0;
    end
  end
endmodule

// File: rtl/wordsync_event_det.sv
module wordsync_event_det
  import wsd_pkg::*;
#(
  parameter int unsigned GAP_LEN  = GAP_RUN_LEN,
  parameter int unsigned DISP_LEN = DISP_RUN_LEN,
  parameter int unsigned ERR_LO   = DISP_ERR_LO,
  parameter int unsigned ERR_HI   = DISP_ERR_HI
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       grp_valid,
  input  logic       grp_idle,
  input  logic       grp_k28_3,
  input  logic       grp_disp_err,
  output logic       sync_event
);
  logic clr, en_gap, en_disp, en_achar;
  logic hit_gap, hit_disp, hit_achar;
  logic event_d;

  wsd_mode_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .grp_valid(grp_valid),
    .clr      (clr),
    .en_gap   (en_gap),
    .en_disp  (en_disp),
    .en_achar (en_achar)
  );

  wsd_gap_det #(.RUN_LEN(GAP_LEN)) u_gap (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .en   (en_gap),
    .idle (grp_idle),
    .hit  (hit_gap)
  );

  wsd_disp_run_det #(
    .RUN_LEN(DISP_LEN),
    .ERR_LO (ERR_LO),
    .ERR_HI (ERR_HI)
  ) u_disp (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .en   (en_disp),
    .idle (grp_idle),
    .derr (grp_disp_err),
    .hit  (hit_disp)
  );

  assign hit_achar = en_achar && grp_k28_3;
  assign event_d   = hit_gap || hit_disp || hit_achar;

  // Registered one-clock pulse.
  always_ff @(posedge clk) begin
    if (!rst_n) sync_event <= 1'b0;
    else        sync_event <= event_d;
  end
endmodule

// File: rtl/wsd_checker.sv
module wsd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       grp_valid,
  input logic       grp_idle,
  input logic       grp_k28_3,
  input logic       sync_event
);
  logic [1:0] chk_mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chk_mode_q <= 2'b00;
    else        chk_mode_q <= mode;
  end

  // R1
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> !sync_event);

  // R2
  a_r2_idle_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && grp_valid && grp_idle) |=> !sync_event);

  // R7
  a_r7_achar_event: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && chk_mode_q == 2'b11 && grp_valid && grp_k28_3) |=> sync_event);

  // R8
  a_r8_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid |=> !sync_event);

  // R9
  a_r9_switch_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != chk_mode_q) |=> !sync_event);

  // R3 / R6: outside the K28.3 mode two pulses cannot be adjacent.
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_event && chk_mode_q != 2'b11) |=> !sync_event);
endmodule

bind wordsync_event_det wsd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .grp_valid (grp_valid),
  .grp_idle  (grp_idle),
  .grp_k28_3 (grp_k28_3),
  .sync_event(sync_event)
);

// File: tb/sim_wordsync_event_det.sv
module sim_wordsync_event_det;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       grp_valid = 1'b0, grp_idle = 1'b0, grp_k28_3 = 1'b0, grp_disp_err = 1'b0;
  logic       sync_event;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wordsync_event_det u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .grp_valid(grp_valid),
    .grp_idle(grp_idle), .grp_k28_3(grp_k28_3), .grp_disp_err(grp_disp_err),
    .sync_event(sync_event)
  );

  // Fields: [6:5] mode, [4] valid, [3] idle, [2] K28.3, [1] disp err, [0] expected event
  localparam int NV = 25;
  localparam logic [6:0] VEC [NV] = '{
    7'b00_1_0_1_0_0,  // R1 K28.3 while off
    7'b00_1_1_0_0_0,  // R1
    7'b01_1_1_0_0_0,  // R9 mode change, discarded
    7'b01_1_1_0_0_0,  // R2 idle 1
    7'b01_1_1_0_0_0,
    7'b01_1_1_0_0_0,
    7'b01_1_1_0_0_0,  // idle 4
    7'b01_1_0_0_0_1,  // R2 non-IDLE after four
    7'b01_1_1_0_0_0,  // R3 short run
    7'b01_1_1_0_0_0,
    7'b01_1_1_0_0_0,
    7'b01_1_0_0_0_0,  // R3 only three idles
    7'b01_1_1_0_0_0,  // R3 long run
    7'b01_1_1_0_0_0,
    7'b01_0_0_0_0_0,  // R8 gap inside run
    7'b01_1_1_0_0_0,
    7'b01_1_1_0_0_0,
    7'b01_1_1_0_0_0,  // five idles
    7'b01_1_0_0_0_1,  // R3 single event
    7'b01_1_0_0_0_0,
    7'b11_1_0_1_0_0,  // R9 switch cycle discards K28.3
    7'b11_1_0_1_0_1,  // R7
    7'b11_1_0_1_0_1,  // R7 back to back
    7'b11_1_0_0_0_0,
    7'b11_0_0_1_0_0   // R8 invalid K28.3
  };

  task automatic apply(input logic [1:0] m, input logic v, input logic i, input logic k,
                       input logic e, input logic exp, input string req);
    @(negedge clk);
    mode = m; grp_valid = v; grp_idle = i; grp_k28_3 = k; grp_disp_err = e;
    @(posedge clk);
    #5;
    n_chk++;
    if (sync_event !== exp) begin
      n_bad++;
      $display("FAIL %s: sync_event=%b expected %b", req, sync_event, exp);
    end
  endtask

  task automatic idles(input int n, input logic [1:0] m, input string req);
    for (int j = 0; j < n; j++) apply(m, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic check_now(input logic exp, input string req);
    n_chk++;
    if (sync_event !== exp) begin
      n_bad++;
      $display("FAIL %s: sync_event=%b expected %b", req, sync_event, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 check_now(1'b0, "R10 in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #5 check_now(1'b0, "R10 after reset");

    for (int n = 0; n < NV; n++)
      apply(VEC[n][6:5], VEC[n][4], VEC[n][3], VEC[n][2], VEC[n][1], VEC[n][0], "table");

    // R4: clean marked run in mode 10
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 switch");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 pos1");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R4 pos2");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R4 pos3");
    idles(12, 2'b10, "R4 pos4-15");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R4 pos16");
    // R6: saturation
    idles(3, 2'b10, "R6 extra idles");
    apply(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 non-IDLE");

    // R5: error at position 5 breaks the run
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5 bad err pos5");
    idles(11, 2'b10, "R5 would-be tail");
    // R5: missing error at position 2; that IDLE restarts as position 1
    apply(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 clear");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5 pos1");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5 restart");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5 pos2");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5 pos3");
    idles(12, 2'b10, "R5 pos4-15");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5 event after restart");

    // R9: a mode change mid-run clears the position
    apply(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 clear");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 pos1");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R9 pos2");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R9 pos3");
    idles(7, 2'b10, "R9 pos4-10");
    apply(2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 to 01");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 back to 10");
    idles(6, 2'b10, "R9 no stale event");

    // R1: long idle run then non-IDLE while off
    idles(2, 2'b00, "R1");
    idles(5, 2'b00, "R1");
    apply(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1 off");

    // R10: reset in the middle of K28.3 traffic
    apply(2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 switch");
    apply(2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #5 check_now(1'b0, "R10 reset clears");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #5 check_now(1'b0, "R10 first cycle");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: done=%b expected 1", done);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule